// File: doc/BRIEF.md
# Video Register Bank with Raster Readback

This block is the register bank of a character-based video generator. A host writes bytes into sixteen byte-wide slots. The bank turns those bytes into the fields that steer the display. These fields cover the window position and size, the character and screen-matrix base addresses, the cell height, the colours, the audio channel controls and the volume. Every byte written is also kept as it was written, so a read returns it unchanged.

Two read addresses are different. They return the raster line the beam is about to reach. That value is built from the live horizontal and vertical counters, the video standard and the frame parity. The raster value looks a fixed number of cycles ahead within the line, and the look-ahead depends on the standard. At the end of the field the value wraps according to the frame type.

Reads are registered: a read strobe captures the selected value, and it appears on the read data port one clock later.

Top module: `vid_regbank`

## Requirements
- R1: After reset, all sixteen stored bytes are zero, all decoded fields are zero, `invert_cells` is 1 and `rd_data` is 0.
- R2: A write stores `wdata` at slot `addr` on the clock edge. A read strobe loads `rd_data` one cycle later, and `rd_data` holds its value while `rd_en` is low. A read from any slot other than 3 and 4 returns the stored byte as it was before any write in the same cycle.
- R3: Slot 0: bit 7 drives `interlace` only while `pal_mode` is 0 (in PAL, `interlace` is 0). Bits 6:0 give `first_col`.
- R4: Slot 1 gives `first_row`. In slot 2, bits 6:0 give `num_cols` and bit 7 becomes bit 9 of `matrix_base`.
- R5: In slot 3, bits 6:1 give `num_rows` and bit 0 gives `tall_chars`. In slot 5, bits 3:0 give `char_base[13:10]` and bits 7:4 give `matrix_base[13:10]`. All other base address bits are 0.
- R6: Slots 10 to 13 appear on `aud_ctrl` as channels 0 to 3, with channel n at bits 8n+7:8n. In slot 14, bits 7:4 give `aux_colour` and bits 3:0 give `volume`.
- R7: In slot 15, bits 2:0 give `border_colour` and bits 7:4 give `bg_colour`. `invert_cells` is the inverse of bit 3.
- R8: The raster line is the vertical count plus (hcount + offset) / line length, using integer division. NTSC (`pal_mode`=0) uses a line length of 65 and an offset of 40. PAL uses a line length of 71 and an offset of 4.
- R9: The field length is 312 in PAL and 261 in NTSC without interlace. In interlaced NTSC it is 262 on odd frames and 263 on even frames. If the predicted line reaches the field length, odd frames and non-interlaced frames return 0 once hcount is at least the wrap position (58 in NTSC, 67 in PAL), and return the field length minus 1 before that. Even interlaced frames return the line modulo the field length.
- R10: A read of slot 3 returns raster bit 0 in bit 7 and the stored bits 6:0. A read of slot 4 returns raster bits 8:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Slot select |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| hcount | input | 7 | Cycle within the line |
| vcount | input | 9 | Line within the field |
| pal_mode | input | 1 | 1 = PAL timing, 0 = NTSC timing |
| odd_frame | input | 1 | Frame parity, 1 = odd |
| interlace | output | 1 | Effective interlace enable |
| first_col | output | 7 | Window start column |
| first_row | output | 8 | Window start row |
| num_cols | output | 7 | Column count |
| num_rows | output | 6 | Row count |
| tall_chars | output | 1 | Sixteen-line cells |
| matrix_base | output | 14 | Screen matrix base address |
| char_base | output | 14 | Character shape base address |
| aud_ctrl | output | 32 | Four audio channel control bytes |
| aux_colour | output | 4 | Auxiliary colour |
| volume | output | 4 | Audio volume |
| border_colour | output | 3 | Border colour |
| bg_colour | output | 4 | Background colour |
| invert_cells | output | 1 | Swap cell foreground and background |
| rd_data | output | 8 | Registered read data |

## Verification
A corrupted stored byte shows on its decoded outputs in the very next cycle. It also shows on `rd_data` one cycle after the slot is read. A wrong raster prediction only surfaces through reads of slots 3 and 4, and it is worst near the end of a line and at the field boundary. For that reason, the stimulus aims at the cycles just around the look-ahead threshold and the wrap position in every frame type, as well as random positions.

// File: rtl/vid_regbank.sv
module vid_regbank #(
  parameter int HW = 7,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic          pal_mode,
  input  logic          odd_frame,
  output logic          interlace,
  output logic [6:0]    first_col,
  output logic [7:0]    first_row,
  output logic [6:0]    num_cols,
  output logic [5:0]    num_rows,
  output logic          tall_chars,
  output logic [13:0]   matrix_base,
  output logic [13:0]   char_base,
  output logic [31:0]   aud_ctrl,
  output logic [3:0]    aux_colour,
  output logic [3:0]    volume,
  output logic [2:0]    border_colour,
  output logic [3:0]    bg_colour,
  output logic          invert_cells,
  output logic [7:0]    rd_data
);
  localparam logic [HW-1:0] NTSC_LEN  = HW'(65);
  localparam logic [HW-1:0] PAL_LEN   = HW'(71);
  localparam logic [HW-1:0] NTSC_OFF  = HW'(40);
  localparam logic [HW-1:0] PAL_OFF   = HW'(4);
  localparam logic [HW-1:0] NTSC_WRAP = HW'(58);
  localparam logic [VW-1:0] NTSC_FLD  = VW'(261);
  localparam logic [VW-1:0] PAL_FLD   = VW'(312);

  logic [7:0] raw_q [16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) raw_q[i] <= 8'h00;
    end else if (wr_en) begin
      raw_q[addr] <= wdata;
    end
  end

  assign interlace     = raw_q[0][7] & ~pal_mode;
  assign first_col     = raw_q[0][6:0];
  assign first_row     = raw_q[1];
  assign num_cols      = raw_q[2][6:0];
  assign num_rows      = raw_q[3][6:1];
  assign tall_chars    = raw_q[3][0];
  assign matrix_base   = {raw_q[5][7:4], raw_q[2][7], 9'd0};
  assign char_base     = {raw_q[5][3:0], 10'd0};
  assign aud_ctrl      = {raw_q[13], raw_q[12], raw_q[11], raw_q[10]};
  assign aux_colour    = raw_q[14][7:4];
  assign volume        = raw_q[14][3:0];
  assign border_colour = raw_q[15][2:0];
  assign bg_colour     = raw_q[15][7:4];
  assign invert_cells  = ~raw_q[15][3];

  logic [HW-1:0] line_len, look_off, wrap_pos;
  logic [VW-1:0] field_len, raster;
  logic [HW:0]   hsum;
  logic [VW:0]   line_n;
  logic          odd_like;

  assign line_len  = pal_mode ? PAL_LEN : NTSC_LEN;
  assign look_off  = pal_mode ? PAL_OFF : NTSC_OFF;
  assign wrap_pos  = pal_mode ? (PAL_LEN - HW'(4)) : NTSC_WRAP;
  assign field_len = interlace ? (odd_frame ? VW'(262) : VW'(263))
                               : (pal_mode ? PAL_FLD : NTSC_FLD);
  assign hsum      = {1'b0, hcount} + {1'b0, look_off};
  assign line_n    = {1'b0, vcount} + {{VW{1'b0}}, (hsum >= {1'b0, line_len})};
  assign odd_like  = odd_frame | ~interlace;

  always_comb begin
    if (line_n < {1'b0, field_len})
      raster = line_n[VW-1:0];
    else if (odd_like)
      raster = (hcount >= wrap_pos) ? '0 : field_len - VW'(1);
    else
      raster = VW'(line_n - {1'b0, field_len});
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (addr)
      4'd3:    rd_mux = {raster[0], raw_q[3][6:0]};
      4'd4:    rd_mux = raster[8:1];
      default: rd_mux = raw_q[addr];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> raw_q[$past(addr)] == $past(wdata));
  assert_rdhold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  assert_pal_nointl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pal_mode |-> !interlace);
  assert_raster_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount < field_len && hcount < line_len) |-> raster < field_len);
  assert_rd3_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd3 && !wr_en) |=> rd_data[6:0] == raw_q[3][6:0]);
endmodule

// File: tb/vid_regbank_test.sv
module vid_regbank_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr_en = 0, rd_en = 0;
  logic [6:0] hcount = 0;
  logic [8:0] vcount = 0;
  logic pal_mode = 0, odd_frame = 0;
  logic interlace, tall_chars, invert_cells;
  logic [6:0] first_col, num_cols;
  logic [7:0] first_row, rd_data;
  logic [5:0] num_rows;
  logic [13:0] matrix_base, char_base;
  logic [31:0] aud_ctrl;
  logic [3:0] aux_colour, volume, bg_colour;
  logic [2:0] border_colour;

  vid_regbank uut (.clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .hcount, .vcount,
    .pal_mode, .odd_frame, .interlace, .first_col, .first_row, .num_cols, .num_rows,
    .tall_chars, .matrix_base, .char_base, .aud_ctrl, .aux_colour, .volume,
    .border_colour, .bg_colour, .invert_cells, .rd_data);

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  int mem [16];
  int exp_rd = 0;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_intl();
    return (((mem[0] >> 7) & 1) == 1 && !pal_mode) ? 1 : 0;
  endfunction

  function automatic int m_field();
    if (m_intl() == 1) return odd_frame ? 262 : 263;
    return pal_mode ? 312 : 261;
  endfunction

  function automatic int m_raster();
    int len  = pal_mode ? 71 : 65;
    int off  = pal_mode ? 4 : 40;
    int wrap = pal_mode ? 67 : 58;
    int fld  = m_field();
    int line = int'(vcount) + (int'(hcount) + off) / len;
    if (line < fld) return line;
    if (odd_frame || m_intl() == 0) return (int'(hcount) >= wrap) ? 0 : fld - 1;
    return line % fld;
  endfunction

  function automatic int m_read(int a);
    int r = m_raster();
    if (a == 3) return ((r & 1) << 7) | (mem[3] & 8'h7f);
    if (a == 4) return (r >> 1) & 8'hff;
    return mem[a];
  endfunction

  task automatic compare_all();
    chk("R3 interlace", int'(interlace), m_intl());
    chk("R3 first_col", int'(first_col), mem[0] & 8'h7f);
    chk("R4 first_row", int'(first_row), mem[1]);
    chk("R4 num_cols", int'(num_cols), mem[2] & 8'h7f);
    chk("R5 num_rows", int'(num_rows), (mem[3] >> 1) & 8'h3f);
    chk("R5 tall_chars", int'(tall_chars), mem[3] & 1);
    chk("R4 R5 matrix_base", int'(matrix_base), ((mem[5] >> 4) << 10) | (((mem[2] >> 7) & 1) << 9));
    chk("R5 char_base", int'(char_base), (mem[5] & 15) << 10);
    for (int c = 0; c < 4; c++)
      chk("R6 aud_ctrl", int'(aud_ctrl[8*c +: 8]), mem[10 + c]);
    chk("R6 aux_colour", int'(aux_colour), mem[14] >> 4);
    chk("R6 volume", int'(volume), mem[14] & 15);
    chk("R7 border", int'(border_colour), mem[15] & 7);
    chk("R7 bg", int'(bg_colour), mem[15] >> 4);
    chk("R7 invert", int'(invert_cells), ((mem[15] >> 3) & 1) ^ 1);
    chk("R2 R8 R9 R10 rd_data", int'(rd_data), exp_rd);
  endtask

  task automatic cycle(bit we, bit re, int a, int d, int h, int v, bit pal, bit odd);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = 4'(a); wdata = 8'(d);
    hcount = 7'(h); vcount = 9'(v); pal_mode = pal; odd_frame = odd;
    @(posedge clk);
    #1;
    if (re) exp_rd = m_read(a);
    if (we) mem[a] = d;
    compare_all();
  endtask

  task automatic rd_at(int a, int h, int v, bit pal, bit odd);
    cycle(0, 1, a, 0, h, v, pal, odd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all(); // R1 reset state
    @(negedge clk); rst_n = 1;
    cycle(0, 0, 0, 0, 0, 0, 0, 0); // R1 after release
    rd_at(7, 0, 0, 0, 0);           // R1 stored zero

    // Decode of every slot (R3..R7), and readback (R2)
    cycle(1, 0, 0, 8'hd5, 0, 0, 0, 0);
    cycle(1, 0, 1, 8'h3c, 0, 0, 0, 0);
    cycle(1, 0, 2, 8'h96, 0, 0, 0, 0);
    cycle(1, 0, 3, 8'h2f, 0, 0, 0, 0);
    cycle(1, 0, 5, 8'ha7, 0, 0, 0, 0);
    for (int c = 10; c < 14; c++) cycle(1, 0, c, 8'h11 * c, 0, 0, 0, 0);
    cycle(1, 0, 14, 8'h9e, 0, 0, 0, 0);
    cycle(1, 0, 15, 8'h6b, 0, 0, 0, 0);
    cycle(1, 0, 15, 8'h63, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 1, 0);  // R3 PAL masks interlace
    for (int a = 0; a < 16; a++) rd_at(a, 10, 20, 0, 1);
    cycle(1, 1, 6, 8'h44, 0, 0, 0, 0); // R2 read sees old byte
    rd_at(6, 0, 0, 0, 0);

    // R8 look-ahead threshold and R9 wrap, NTSC non-interlaced
    cycle(1, 0, 0, 8'h05, 0, 0, 0, 0);
    rd_at(4, 24, 100, 0, 1); rd_at(3, 24, 100, 0, 1);
    rd_at(4, 25, 100, 0, 1); rd_at(3, 25, 100, 0, 1);
    rd_at(4, 25, 260, 0, 0); rd_at(3, 25, 260, 0, 0);
    rd_at(4, 57, 260, 0, 0); rd_at(4, 58, 260, 0, 0); rd_at(3, 58, 260, 0, 0);
    // PAL, R8 and R9
    rd_at(4, 66, 311, 1, 0); rd_at(3, 66, 311, 1, 0);
    rd_at(4, 67, 311, 1, 0); rd_at(3, 67, 311, 1, 0);
    rd_at(3, 70, 150, 1, 1); rd_at(3, 66, 150, 1, 1);
    // Interlaced NTSC, odd and even frames (R9)
    cycle(1, 0, 0, 8'h85, 0, 0, 0, 0);
    rd_at(4, 30, 261, 0, 1); rd_at(3, 30, 261, 0, 1);
    rd_at(4, 58, 261, 0, 1); rd_at(3, 58, 261, 0, 1);
    rd_at(4, 30, 262, 0, 0); rd_at(3, 30, 262, 0, 0);
    rd_at(3, 24, 262, 0, 0); rd_at(4, 60, 262, 0, 0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bit pal = 1'($urandom);
      bit odd = 1'($urandom);
      int len = pal ? 71 : 65;
      int fld;
      int a = $urandom_range(0, 15);
      bit we = ($urandom_range(0, 3) == 0);
      bit re = ($urandom_range(0, 2) != 0);
      if (we && a == 0 && !pal) fld = 263;
      else if (((mem[0] >> 7) & 1) == 1 && !pal) fld = odd ? 262 : 263;
      else fld = pal ? 312 : 261;
      if (we && a == 0) fld = (fld > 261) ? 261 : fld;
      cycle(we, re, a, $urandom_range(0, 255), $urandom_range(0, len - 1),
            $urandom_range(fld - 3, fld - 1) * (n % 2) + $urandom_range(0, fld - 4) * (1 - n % 2),
            pal, odd);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule